// File: doc/BRIEF.md
# Nested Loop Iteration Controller

This block replaces a software loop nest with a hardware sequencer. It holds one down-counter for each loop level. A start request copies a runtime bound into every level. The controller then emits one body strobe per innermost iteration, together with the current iteration index of every level. The innermost level steps on every strobe. When a level finishes its last iteration it reloads itself from its stored bound, and in the same cycle it lets the next outer level step once. This repeats up the chain. When every level is on its final iteration, the nest ends.

A loop body datapath attached to the controller uses `body_valid` and the index outputs to do its work. It uses the per-level wrap pulses to close partial results at the end of each level. It can raise any bit of an exit request vector to cut the nest short. The bits are OR-combined, so any level's exit condition ends the whole nest. A one-cycle `done` pulse marks the end of every run, whether the nest completed or was cut short.

Levels are numbered from the inside out. Level 0 is the innermost loop. Bounds and indices travel in flat vectors, with level `l` in bits `[CW*l +: CW]`.

Top module: `nest_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes idle. After that edge, `body_valid`, `done`, every `wrap` bit and every index read 0.
- R2: A `start` seen while idle and with `done` low captures all bounds. If every bound is nonzero, the first `body_valid` appears in the cycle after that edge, and every index reads 0.
- R3: `body_valid` is high for exactly one cycle per innermost iteration, for a total of b0·b1·b2 consecutive cycles. On strobe k: index 0 is k mod b0, index 1 is (k div b0) mod b1, and index 2 is k div (b0·b1).
- R4: On a strobe cycle, `wrap[l]` is high exactly when levels 0..l all show their final index, bound−1. It is 0 on all other cycles.
- R5: `done` is high for exactly one cycle. It follows the last strobe of a completed nest, and no strobe occurs in the `done` cycle.
- R6: If any bound is 0 when `start` is accepted, `done` pulses in the next cycle and no strobe is produced.
- R7: If any bit of `exit_req` is high in a strobe cycle, that strobe still counts. No later strobe occurs, and `done` pulses in the following cycle.
- R8: `exit_req` has no effect while the controller is idle. `done` and `body_valid` stay low.
- R9: `start` is ignored while a nest is running and in the `done` cycle. The running sequence continues unchanged.
- R10: Bound inputs are sampled only when `start` is accepted. Changing them during a run does not alter the sequence.
- R11: When not running, all counters hold, `body_valid` is 0 and every index output reads 0.
- R12: Bounds of up to 2^CW−1 per level are supported. The default setting is CW=4, for bounds up to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a nest with the bounds on `bound_in` |
| bound_in | input | LEVELS*CW | Per-level iteration bounds, level 0 (innermost) in the low bits |
| exit_req | input | LEVELS | Per-level early-exit conditions, OR-combined |
| idx_out | output | LEVELS*CW | Current iteration index of each level, counting from 0 |
| body_valid | output | 1 | One strobe per innermost iteration |
| wrap | output | LEVELS | Level finishes its last iteration on this strobe |
| done | output | 1 | One-cycle end-of-nest pulse |

## Verification
The bench runs every bound combination with each level taken from 0 to 3. This covers zero-bound aborts, single-iteration levels and levels that repeat, and it separates errors in each level's carry from errors in the index arithmetic. A full 12×12×12 nest and a run with level bounds of 15 test long carries and counter width. Early exits are placed on the first strobe, on a strobe in the middle of the nest, on a wrap strobe and on the final strobe. This tells whether the exiting strobe is kept and whether the pulses that follow are suppressed. A `start` with new bounds injected mid-run, and idle exit pulses, show that inputs outside their window are ignored.

// File: rtl/nest_pkg.sv
package nest_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } nest_state_e;

    typedef struct packed {
        logic load;
        logic run;
        logic fin;
    } ctrl_flags_t;

    function automatic logic is_last(input logic [15:0] remaining);
        return remaining == 16'd1;
    endfunction

endpackage

// File: rtl/nest_exit_or.sv
module nest_exit_or #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic         any
);
    logic [N:0] acc;
    assign acc[0] = 1'b0;
    generate
        for (genvar i = 0; i < N; i++) begin : g_or
            assign acc[i+1] = acc[i] | req[i];
        end
    endgenerate
    assign any = acc[N];
endmodule

// File: rtl/nest_level.sv
module nest_level #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] bound_in,
    input  logic          step,
    input  logic          run,
    output logic          last,
    output logic [CW-1:0] idx
);
    import nest_pkg::*;

    logic [CW-1:0] bnd_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            bnd_q <= bound_in;
            cnt_q <= bound_in;
        end else if (step) begin
            if (last) cnt_q <= bnd_q;
            else      cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = is_last(16'(cnt_q));
    assign idx  = run ? (bnd_q - cnt_q) : '0;

    // R3: while running, remaining count stays within 1..bound
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q != '0 && cnt_q <= bnd_q));

    // R11: counters hold unless loaded or stepped
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(cnt_q));

    // R10: stored bound changes only on a load
    p_bound_kept_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bnd_q));
endmodule

// File: rtl/nest_ctrl.sv
module nest_ctrl (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  any_zero,
    input  logic                  exit_any,
    input  logic                  final_iter,
    output nest_pkg::ctrl_flags_t flags
);
    import nest_pkg::*;

    nest_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = any_zero ? ST_FIN : ST_RUN;
            ST_RUN:  if (exit_any || final_iter) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign flags.load = (st_q == ST_IDLE) && start;
    assign flags.run  = (st_q == ST_RUN);
    assign flags.fin  = (st_q == ST_FIN);

    // R5: the end pulse never lasts two cycles
    p_fin_single_r5: assert property (@(posedge clk) disable iff (rst)
        flags.fin |=> !flags.fin);

    // R9: a start while running does not leave the run state early
    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (flags.run && start && !exit_any && !final_iter) |=> flags.run);

    // R6: a zero bound at start goes straight to the end pulse
    p_zero_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (flags.load && any_zero) |=> flags.fin);
endmodule

// File: rtl/nest_seq.sv
module nest_seq #(
    parameter int LEVELS = 3,
    parameter int CW     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LEVELS*CW-1:0] bound_in,
    input  logic [LEVELS-1:0]    exit_req,
    output logic [LEVELS*CW-1:0] idx_out,
    output logic                 body_valid,
    output logic [LEVELS-1:0]    wrap,
    output logic                 done
);
    import nest_pkg::*;

    ctrl_flags_t       flags;
    logic              exit_any;
    logic [LEVELS-1:0] last;
    logic [LEVELS:0]   carry;
    logic [LEVELS:0]   zero_acc;

    nest_exit_or #(.N(LEVELS)) u_exit (
        .req (exit_req),
        .any (exit_any)
    );

    assign carry[0]    = 1'b1;
    assign zero_acc[0] = 1'b0;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            assign zero_acc[l+1] = zero_acc[l] | (bound_in[CW*l +: CW] == '0);
            assign carry[l+1]    = carry[l] & last[l];
            assign wrap[l]       = flags.run & carry[l+1];

            nest_level #(.CW(CW)) u_level (
                .clk      (clk),
                .rst      (rst),
                .load     (flags.load),
                .bound_in (bound_in[CW*l +: CW]),
                .step     (flags.run & carry[l]),
                .run      (flags.run),
                .last     (last[l]),
                .idx      (idx_out[CW*l +: CW])
            );

            if (l > 0) begin : g_nest_chk
                // R4: an outer wrap implies every inner level wraps too
                p_wrap_nested_r4: assert property (@(posedge clk) disable iff (rst)
                    wrap[l] |-> wrap[l-1]);
            end
        end
    endgenerate

    nest_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .any_zero   (zero_acc[LEVELS]),
        .exit_any   (exit_any),
        .final_iter (carry[LEVELS]),
        .flags      (flags)
    );

    assign body_valid = flags.run;
    assign done       = flags.fin;

    // R4: wraps only occur on strobe cycles
    p_wrap_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |-> body_valid);

    // R7: an exit on a strobe ends the nest in the next cycle
    p_exit_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (body_valid && |exit_req) |=> (!body_valid && done));

    // R5: outermost wrap is followed by the end pulse
    p_last_done_r5: assert property (@(posedge clk) disable iff (rst)
        (body_valid && wrap[LEVELS-1]) |=> (done && !body_valid));

    // R8: exit requests while idle never start an end pulse
    p_idle_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (!body_valid && !done && !start) |=> !done);
endmodule

// File: tb/nest_seq_test.sv
module nest_seq_test;
    localparam int LEVELS = 3;
    localparam int CW     = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [LEVELS*CW-1:0] bound_in = '0;
    logic [LEVELS-1:0]    exit_req = '0;
    logic [LEVELS*CW-1:0] idx_out;
    logic                 body_valid;
    logic [LEVELS-1:0]    wrap;
    logic                 done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    nest_seq #(.LEVELS(LEVELS), .CW(CW)) uut (
        .clk(clk), .rst(rst), .start(start), .bound_in(bound_in),
        .exit_req(exit_req), .idx_out(idx_out), .body_valid(body_valid),
        .wrap(wrap), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ex: strobe index carrying an exit (-1 none); poke: strobe index at which
    // start and new bounds are applied (-1 none)
    task automatic run_nest(input int b0, input int b1, input int b2,
                            input int ex, input int exbit, input int poke);
        int total, expect_n;
        logic [LEVELS*CW-1:0] exp_idx;
        logic [LEVELS-1:0]    exp_wrap;
        int i0, i1, i2;
        total    = b0 * b1 * b2;
        expect_n = (ex >= 0 && ex + 1 < total) ? ex + 1 : total;
        @(negedge clk);
        bound_in = {CW'(b2), CW'(b1), CW'(b0)};
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        for (int k = 0; k < expect_n; k++) begin
            i0 = k % b0;
            i1 = (k / b0) % b1;
            i2 = k / (b0 * b1);
            exp_idx     = {CW'(i2), CW'(i1), CW'(i0)};
            exp_wrap[0] = (i0 == b0 - 1);
            exp_wrap[1] = exp_wrap[0] && (i1 == b1 - 1);
            exp_wrap[2] = exp_wrap[1] && (i2 == b2 - 1);
            if (k == 0) check(idx_out == '0 && body_valid, "R2 first strobe", idx_out, 0);
            check(body_valid && !done, "R3 strobe present", {body_valid, done}, 2'b10);
            check(idx_out == exp_idx, "R3 index", idx_out, exp_idx);
            check(wrap == exp_wrap, "R4 wrap", wrap, exp_wrap);
            exit_req = (k == ex) ? LEVELS'(1 << exbit) : '0;
            if (k == poke) begin
                start    = 1'b1;
                bound_in = {CW'(1), CW'(1), CW'(1)};
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        exit_req = '0;
        start    = 1'b0;
        if (total == 0)
            check(done && !body_valid, "R6 zero bound abort", {done, body_valid}, 2'b10);
        else if (expect_n < total)
            check(done && !body_valid, "R7 exit ends nest", {done, body_valid}, 2'b10);
        else
            check(done && !body_valid, "R5 done after last", {done, body_valid}, 2'b10);
        @(negedge clk);
        check(!done && !body_valid, "R5 single done pulse", {done, body_valid}, 2'b00);
        check(idx_out == '0 && wrap == '0, "R11 idle outputs", {idx_out, wrap}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!body_valid && !done && wrap == '0 && idx_out == '0, "R1 reset state",
              {body_valid, done, wrap, idx_out}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R8: idle exits ignored
        exit_req = '1;
        repeat (3) begin
            @(negedge clk);
            check(!done && !body_valid, "R8 idle exit", {done, body_valid}, 0);
        end
        exit_req = '0;

        // R3 R4 R5 R6: sweep of small bounds
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    run_nest(a, b, c, -1, 0, -1);

        // R3: reference 12x12x12 nest
        run_nest(12, 12, 12, -1, 0, -1);
        // R12: widest bounds
        run_nest(15, 1, 15, -1, 0, -1);

        // R7: early exits from each level's bit, at various points
        run_nest(3, 3, 3, 0, 0, -1);
        run_nest(3, 3, 3, 13, 1, -1);
        run_nest(3, 3, 3, 8, 2, -1);
        run_nest(3, 3, 3, 26, 1, -1);

        // R9 R10: start with new bounds during a run is ignored
        run_nest(4, 3, 2, -1, 0, 5);
        run_nest(2, 2, 2, -1, 0, 0);

        // R1: reset in mid-run
        @(negedge clk);
        bound_in = {CW'(3), CW'(3), CW'(3)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!body_valid && !done && idx_out == '0, "R1 reset mid-run",
              {body_valid, done, idx_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!body_valid && !done, "R11 idle after reset", {body_valid, done}, 0);
        run_nest(2, 3, 1, -1, 0, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule